// File: doc/BRIEF.md
# I2C Line Control and Bus Monitor

This block sits between the sequencing logic of an I2C controller and the two open-drain bus lines. On every system clock it decides whether the data line and the clock line are pulled low. It serves both the master role and the slave role. The sequencer tells it the role, the current phase of the transfer, the bit to send, and whether the bus is owned or arbitration was lost. A clock generator supplies a strobe at the middle of each SCL low phase and the internal SCL level.

The block also watches the synchronized bus lines for START and STOP events and keeps a bus-busy flag. It raises a one-cycle cancel pulse when a STOP is seen or when a slave address mismatch is reported. The controller uses that pulse to abandon the transfer and to reset its bit-clock generator. Both pull outputs are active-high pull-down enables: 1 pulls the line low and 0 releases it. The block never drives a line high.

Top module: `i2c_line_ctrl`

## Requirements
- R1: A falling SDA while SCL is high raises `start_det` for exactly one cycle. The flag rises on the third rising clock edge after the pin change: two synchronizer stages, then the detection register.
- R2: A rising SDA while SCL is high raises `stop_det` for one cycle, with the same latency as R1. SDA changes while SCL is low raise neither flag.
- R3: `busy` becomes 1 together with `start_det` and returns to 0 together with `stop_det`. A repeated START keeps it at 1.
- R4: `cancel` is a one-cycle pulse. It is raised together with `stop_det`, or on the first rising edge after `addr_mismatch` rises while `is_master` is 0. `addr_mismatch` in the master role has no effect. A cancel releases SDA (`sda_pull` = 0) on the same edge.
- R5: Outside master START/STOP/repeated-START generation, `sda_pull` takes a new value only on the edge that follows a cycle with `mid_low` = 1, and holds at all other times.
- R6: The phase code is 0 idle, 1 data transmit, 2 acknowledge of a received byte, 3 address acknowledge, 4 acknowledge receive, 5 START generation, 6 STOP generation, 7 repeated-START generation. In the master role, `sda_pull` becomes 1 for phase 1 with `tx_bit` = 0 and for phase 2. It becomes 0 for phases 0, 3 and 4, and for phase 1 with `tx_bit` = 1.
- R7: In the slave role, `sda_pull` becomes 1 for phase 3, for phase 2, and for phase 1 with `tx_bit` = 0. It becomes 0 for all other phases, including 5 to 7.
- R8: In the master role during phases 5 to 7, `sda_pull` follows `gen_sda_low` one edge later on every cycle, without waiting for `mid_low`.
- R9: `scl_pull` is 1 one edge after `scl_int` is 0, provided the master role holds and at least one of these is true: `bus_owner` is 1, `arb_lost` is 1, or the phase is 5 to 7. In every other case `scl_pull` is 0, and in the slave role it is always 0.
- R10: While `rst_n` is 0, `busy`, `start_det`, `stop_det`, `cancel`, `sda_pull` and `scl_pull` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| mid_low | input | 1 | Strobe at the middle of an SCL low phase |
| scl_int | input | 1 | Internal SCL level from the clock generator |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| bus_owner | input | 1 | Master currently owns the bus |
| arb_lost | input | 1 | Master has lost arbitration |
| phase | input | 3 | Transfer phase code (see R6) |
| tx_bit | input | 1 | Data bit to transmit |
| gen_sda_low | input | 1 | SDA level wanted during condition generation (1 = low) |
| addr_mismatch | input | 1 | Slave address compare failed |
| sda_pull | output | 1 | Pull SDA low |
| scl_pull | output | 1 | Pull SCL low |
| busy | output | 1 | Bus busy between START and STOP |
| start_det | output | 1 | One-cycle START detected |
| stop_det | output | 1 | One-cycle STOP detected |
| cancel | output | 1 | One-cycle transfer abort / clock generator reset |

## Verification
The bench toggles SDA while SCL is low. A detector that ignored the SCL level would report false STOPs and STARTs there, and the scoreboard would see events it never queued. The bench also sends a repeated START during a busy bus and checks that the line is still busy, which exposes a busy flag that toggles on every START. It changes `tx_bit` and the phase without a mid-low strobe to catch a driver that updates SDA early. It raises an address mismatch in the master role, where a wrong design would emit a stray cancel. A held mismatch level tests that cancel stays one cycle wide, and a reset taken during a busy bus must leave no phantom START once reset is released.

// File: rtl/i2c_line_pkg.sv
package i2c_line_pkg;

  localparam int unsigned PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE      = 3'd0,
    PH_DATA_TX   = 3'd1,
    PH_ACK_TX    = 3'd2,
    PH_ADDR_ACK  = 3'd3,
    PH_ACK_RX    = 3'd4,
    PH_GEN_START = 3'd5,
    PH_GEN_STOP  = 3'd6,
    PH_GEN_RST   = 3'd7
  } phase_e;

  function automatic logic is_gen_phase(input phase_e p);
    return (p == PH_GEN_START) || (p == PH_GEN_STOP) || (p == PH_GEN_RST);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d[g]};
    end

    // idle bus lines are high, so the chain resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign q[g] = chain_q[LAST];
  end

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic is_master,
  input  logic addr_mismatch,
  output logic start_det,
  output logic stop_det,
  output logic busy,
  output logic cancel,
  output logic cancel_now
);

  logic scl_p, sda_p, mm_q;
  logic start_q, stop_q, busy_q, cancel_q;
  logic start_raw, stop_raw, mm_rise, busy_d;

  always_comb begin
    start_raw  = scl_s & scl_p & sda_p & ~sda_s;
    stop_raw   = scl_s & scl_p & ~sda_p & sda_s;
    mm_rise    = addr_mismatch & ~mm_q & ~is_master;
    cancel_now = (stop_raw | mm_rise) & ~cancel_q;
    busy_d     = busy_q;
    if (start_raw)     busy_d = 1'b1;
    else if (stop_raw) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      mm_q     <= 1'b0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      busy_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      scl_p    <= scl_s;
      sda_p    <= sda_s;
      mm_q     <= addr_mismatch;
      start_q  <= start_raw;
      stop_q   <= stop_raw;
      busy_q   <= busy_d;
      cancel_q <= cancel_now;
    end
  end

  assign start_det = start_q;
  assign stop_det  = stop_q;
  assign busy      = busy_q;
  assign cancel    = cancel_q;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q); // R3
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !busy_q); // R3
  AST_CANCEL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_q |=> !cancel_q); // R4
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R1

endmodule

// File: rtl/i2c_sda_drive.sv
module i2c_sda_drive
  import i2c_line_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   is_master,
  input  phase_e phase,
  input  logic   tx_bit,
  input  logic   gen_sda_low,
  input  logic   mid_low,
  input  logic   cancel_now,
  output logic   sda_pull
);

  logic want_low, gen_now, upd_en, sda_d, sda_q;

  always_comb begin
    gen_now  = is_master & is_gen_phase(phase);
    want_low = 1'b0;
    unique case (phase)
      PH_DATA_TX:  want_low = ~tx_bit;
      PH_ACK_TX:   want_low = 1'b1;
      PH_ADDR_ACK: want_low = ~is_master;
      PH_GEN_START,
      PH_GEN_STOP,
      PH_GEN_RST:  want_low = is_master & gen_sda_low;
      default:     want_low = 1'b0;
    endcase
    upd_en = gen_now | mid_low;
    sda_d  = sda_q;
    if (cancel_now)  sda_d = 1'b0;
    else if (upd_en) sda_d = want_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_q <= 1'b0;
    else        sda_q <= sda_d;
  end

  assign sda_pull = sda_q;

  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_now && !mid_low && !cancel_now) |=> $stable(sda_q)); // R5
  AST_CANCEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_now |=> !sda_q); // R4

endmodule

// File: rtl/i2c_scl_drive.sv
module i2c_scl_drive
  import i2c_line_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   is_master,
  input  logic   bus_owner,
  input  logic   arb_lost,
  input  phase_e phase,
  input  logic   scl_int,
  output logic   scl_pull
);

  logic follow, scl_d, scl_q;

  always_comb begin
    follow = is_master & (bus_owner | arb_lost | is_gen_phase(phase));
    scl_d  = follow & ~scl_int;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b0;
    else        scl_q <= scl_d;
  end

  assign scl_pull = scl_q;

  AST_SLAVE_NO_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> !scl_q); // R9
  AST_SCL_HIGH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_int |=> !scl_q); // R9

endmodule

// File: rtl/i2c_line_ctrl.sv
module i2c_line_ctrl
  import i2c_line_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_in,
  input  logic         sda_in,
  input  logic         mid_low,
  input  logic         scl_int,
  input  logic         is_master,
  input  logic         bus_owner,
  input  logic         arb_lost,
  input  logic [2:0]   phase,
  input  logic         tx_bit,
  input  logic         gen_sda_low,
  input  logic         addr_mismatch,
  output logic         sda_pull,
  output logic         scl_pull,
  output logic         busy,
  output logic         start_det,
  output logic         stop_det,
  output logic         cancel
);

  logic [1:0] line_s;
  logic       cancel_now;
  phase_e     phase_q;

  assign phase_q = phase_e'(phase);

  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (line_s)
  );

  i2c_bus_monitor u_mon (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_s         (line_s[1]),
    .sda_s         (line_s[0]),
    .is_master     (is_master),
    .addr_mismatch (addr_mismatch),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .busy          (busy),
    .cancel        (cancel),
    .cancel_now    (cancel_now)
  );

  i2c_sda_drive u_sda (
    .clk         (clk),
    .rst_n       (rst_n),
    .is_master   (is_master),
    .phase       (phase_q),
    .tx_bit      (tx_bit),
    .gen_sda_low (gen_sda_low),
    .mid_low     (mid_low),
    .cancel_now  (cancel_now),
    .sda_pull    (sda_pull)
  );

  i2c_scl_drive u_scl (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_master (is_master),
    .bus_owner (bus_owner),
    .arb_lost  (arb_lost),
    .phase     (phase_q),
    .scl_int   (scl_int),
    .scl_pull  (scl_pull)
  );

endmodule

// File: tb/i2c_line_ctrl_bench.sv
module i2c_line_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, mid_low = 1'b0, scl_int = 1'b1;
  logic is_master = 1'b1, bus_owner = 1'b0, arb_lost = 1'b0;
  logic [2:0] phase = 3'd0;
  logic tx_bit = 1'b1, gen_sda_low = 1'b0, addr_mismatch = 1'b0;
  logic sda_pull, scl_pull, busy, start_det, stop_det, cancel;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  logic [2:0] exp_q[$];

  always #5 clk = ~clk;

  i2c_line_ctrl u_i2c_line_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .mid_low(mid_low), .scl_int(scl_int), .is_master(is_master),
    .bus_owner(bus_owner), .arb_lost(arb_lost), .phase(phase),
    .tx_bit(tx_bit), .gen_sda_low(gen_sda_low), .addr_mismatch(addr_mismatch),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .busy(busy),
    .start_det(start_det), .stop_det(stop_det), .cancel(cancel)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every event vector {start,stop,cancel} must match the queue head
  always @(negedge clk) begin
    cyc++;
    if (rst_n && ({start_det, stop_det, cancel} != 3'b000)) begin
      if (exp_q.size() == 0) begin
        check("R1/R2/R4 unexpected event", {1'b0, start_det, stop_det, cancel}, 4'h0);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check("R1/R2/R4 event", {1'b0, start_det, stop_det, cancel}, {1'b0, e});
      end
    end
    if (cyc > 100000) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_mid();
    @(negedge clk) mid_low = 1'b1;
    @(negedge clk) mid_low = 1'b0;
  endtask

  // SDA falls with SCL high; start_det expected on the third edge (R1)
  task automatic bus_start();
    exp_q.push_back(3'b100);
    @(negedge clk) sda_in = 1'b0;
    wait_n(2);
    check("R1 start latency early", {3'b0, start_det}, 4'h0);
    @(negedge clk);
    check("R1 start flag", {3'b0, start_det}, 4'h1);
    check("R3 busy on start", {3'b0, busy}, 4'h1);
    @(negedge clk);
    check("R1 start one cycle", {3'b0, start_det}, 4'h0);
    wait_n(2);
    scl_in = 1'b0;
    wait_n(4);
  endtask

  task automatic bus_stop();
    sda_in = 1'b0;
    wait_n(4);
    scl_in = 1'b1;
    wait_n(4);
    exp_q.push_back(3'b011);
    sda_in = 1'b1;
    wait_n(3);
    check("R2 stop flag", {3'b0, stop_det}, 4'h1);
    check("R4 cancel with stop", {3'b0, cancel}, 4'h1);
    check("R3 idle on stop", {3'b0, busy}, 4'h0);
    wait_n(3);
  endtask

  initial begin
    wait_n(3);
    check("R10 reset outputs", {busy, start_det, stop_det, cancel}, 4'h0);
    check("R10 reset pulls", {2'b0, sda_pull, scl_pull}, 4'h0);
    @(negedge clk) rst_n = 1'b1;
    wait_n(3);

    // bus monitor: start, data toggles with SCL low, repeated start, stop
    bus_start();
    sda_in = 1'b1; wait_n(4); sda_in = 1'b0; wait_n(4); sda_in = 1'b1; wait_n(4);
    check("R2 no event on SCL-low toggles", {3'b0, busy}, 4'h1);
    scl_in = 1'b1; wait_n(4);
    bus_start();
    check("R3 busy after repeated start", {3'b0, busy}, 4'h1);
    bus_stop();

    // master SDA decisions, held until mid_low (R5, R6)
    is_master = 1'b1; phase = 3'd1; tx_bit = 1'b0;
    wait_n(3);
    check("R5 hold without mid_low", {3'b0, sda_pull}, 4'h0);
    pulse_mid();
    check("R6 master tx zero", {3'b0, sda_pull}, 4'h1);
    tx_bit = 1'b1; wait_n(3);
    check("R5 hold after tx_bit change", {3'b0, sda_pull}, 4'h1);
    pulse_mid();
    check("R6 master tx one", {3'b0, sda_pull}, 4'h0);
    phase = 3'd2; pulse_mid();
    check("R6 master ack of rx byte", {3'b0, sda_pull}, 4'h1);
    phase = 3'd4; wait_n(2);
    check("R5 hold across phase change", {3'b0, sda_pull}, 4'h1);
    pulse_mid();
    check("R6 master ack receive releases", {3'b0, sda_pull}, 4'h0);
    phase = 3'd3; pulse_mid();
    check("R6 master no address ack", {3'b0, sda_pull}, 4'h0);

    // generation phases track gen_sda_low every cycle (R8)
    phase = 3'd5; gen_sda_low = 1'b1;
    @(negedge clk);
    check("R8 gen start pulls", {3'b0, sda_pull}, 4'h1);
    phase = 3'd6; gen_sda_low = 1'b0;
    @(negedge clk);
    check("R8 gen stop releases", {3'b0, sda_pull}, 4'h0);
    phase = 3'd7; gen_sda_low = 1'b1;
    @(negedge clk);
    check("R8 gen restart pulls", {3'b0, sda_pull}, 4'h1);

    // slave SDA decisions (R7)
    is_master = 1'b0; gen_sda_low = 1'b1; phase = 3'd5; pulse_mid();
    check("R7 slave ignores gen phase", {3'b0, sda_pull}, 4'h0);
    phase = 3'd1; tx_bit = 1'b0; pulse_mid();
    check("R7 slave tx zero", {3'b0, sda_pull}, 4'h1);
    phase = 3'd4; pulse_mid();
    check("R7 slave ack receive releases", {3'b0, sda_pull}, 4'h0);
    phase = 3'd2; pulse_mid();
    check("R7 slave ack of rx byte", {3'b0, sda_pull}, 4'h1);
    phase = 3'd3; pulse_mid();
    check("R7 slave address ack", {3'b0, sda_pull}, 4'h1);

    // slave mismatch cancels and releases SDA (R4)
    exp_q.push_back(3'b001);
    @(negedge clk) addr_mismatch = 1'b1;
    @(negedge clk);
    check("R4 cancel on mismatch", {3'b0, cancel}, 4'h1);
    check("R4 cancel releases sda", {3'b0, sda_pull}, 4'h0);
    @(negedge clk);
    check("R4 cancel single cycle", {3'b0, cancel}, 4'h0);
    wait_n(2);
    addr_mismatch = 1'b0;
    is_master = 1'b1; wait_n(2);
    @(negedge clk) addr_mismatch = 1'b1;
    wait_n(2);
    check("R4 master mismatch ignored", {3'b0, cancel}, 4'h0);
    addr_mismatch = 1'b0;

    // SCL follow rules (R9)
    phase = 3'd1; bus_owner = 1'b1; scl_int = 1'b0;
    @(negedge clk);
    check("R9 owner follows low", {3'b0, scl_pull}, 4'h1);
    scl_int = 1'b1; @(negedge clk);
    check("R9 owner follows high", {3'b0, scl_pull}, 4'h0);
    bus_owner = 1'b0; scl_int = 1'b0; @(negedge clk);
    check("R9 non-owner released", {3'b0, scl_pull}, 4'h0);
    arb_lost = 1'b1; @(negedge clk);
    check("R9 follows after arbitration loss", {3'b0, scl_pull}, 4'h1);
    arb_lost = 1'b0; phase = 3'd6; @(negedge clk);
    check("R9 follows in stop generation", {3'b0, scl_pull}, 4'h1);
    is_master = 1'b0; bus_owner = 1'b1; @(negedge clk);
    check("R9 slave never pulls scl", {3'b0, scl_pull}, 4'h0);
    bus_owner = 1'b0; scl_int = 1'b1; phase = 3'd0;

    // reset during a busy bus (R10)
    bus_start();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears busy", {3'b0, busy}, 4'h0);
    @(negedge clk) rst_n = 1'b1;
    wait_n(6);
    check("R10 no phantom start after reset", {3'b0, busy}, 4'h0);

    check("R1/R2/R4 queue drained", exp_q.size() == 0 ? 4'h1 : 4'h0, 4'h1);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule